// File: doc/BRIEF.md
# Stereo Sample Input Buffer with Default Fallback

This block takes audio samples for a left and a right channel from a simple write port and hands them, one pair at a time, to a downstream converter. Each channel has its own small first-in first-out store of 16-bit words. A counter divides a converter tick input. Every 256 ticks it raises a pull strobe, and both channels give up their oldest word at the same time.

A channel whose store is empty at pull time does not underflow. It outputs the contents of a shared default register instead, normally a midpoint or zero code. After each pull, every channel checks its store and may raise a one-cycle interrupt pulse. A per-channel type input picks the cause: either an empty store or a store that has room. The pulse also sets a sticky flag, which a write-one-to-clear input resets. Status outputs give the full and empty state of each store. The software or DMA side uses the pulses to keep the stores topped up.

Top module: `stereo_sample_fifo`

## Requirements
- R1: Each channel store holds at most DEPTH (default 4) words. A write to a full store with no pull in that cycle is dropped, and the stored words are not disturbed.
- R2: While enable is high, the pull strobe fires on the first converter tick after enable rises and then on every RATIO-th (default 256) tick after that. `smp_vld_o` goes high for one cycle, in the cycle after the pull tick, and stays low at all other times.
- R3: When a channel store is empty at a pull, that channel's sample output takes the default register value. The default register is loaded from `wr_data_i` when `dflt_we_i` is high and resets to 0.
- R4: A channel write made while `en_i` is low is dropped.
- R5: With type bit 1, a channel pulses `irq_pulse_o` one cycle after a pull only if its store is empty after that pull.
- R6: With type bit 0, a channel pulses `irq_pulse_o` one cycle after a pull only if its store is not full after that pull.
- R7: On the first enable with empty stores, the first pull gives the default value on both channels, and with type 0 it raises both interrupt pulses.
- R8: `empty_o` and `full_o` show each store's occupancy. After reset, `empty_o` is 2'b11 and `full_o` is 2'b00. Bit 0 is left and bit 1 is right in every two-bit port.
- R9: A pulse sets the channel's `irq_flag_o` on the next edge. The flag stays set until a cycle with `irq_clr_i` high for that bit and no new pulse.
- R10: A write and a pull in the same cycle on a full store are both carried out. The oldest word leaves, the new word is stored, and the store stays full.
- R11: The two channel stores are independent. A write to one does not change the other's status or samples.
- R12: Words leave a store in the order they were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Module enable |
| conv_tick_i | input | 1 | One converter clock tick |
| wr_data_i | input | DW | Write data for channels and default register |
| wr_left_i | input | 1 | Push `wr_data_i` into the left store |
| wr_right_i | input | 1 | Push `wr_data_i` into the right store |
| dflt_we_i | input | 1 | Load the default register |
| irq_type_i | input | 2 | Interrupt cause per channel: 1 empty, 0 not full |
| irq_clr_i | input | 2 | Write-one-to-clear for the interrupt flags |
| smp_left_o | output | DW | Left sample from the last pull |
| smp_right_o | output | DW | Right sample from the last pull |
| smp_vld_o | output | 1 | One-cycle marker that new samples are present |
| full_o | output | 2 | Store full per channel |
| empty_o | output | 2 | Store empty per channel |
| irq_pulse_o | output | 2 | Interrupt pulse per channel |
| irq_flag_o | output | 2 | Sticky interrupt flag per channel |

## Verification
A wrong occupancy count shows right away on `full_o` and `empty_o`. At the next pull it also shows as a sample that was replaced by the default word, or as a stored word that should have become the default. A wrong read pointer shows as a reordered sample at the next pull, and a wrong tick count shows as `smp_vld_o` arriving early or late by whole ticks. Interrupt faults show on `irq_pulse_o` one cycle after the pull and on the flag one cycle after that. Each test therefore drains what it writes and checks every pull.

// File: rtl/ssf_pkg.sv
`timescale 1ns/1ps
package ssf_pkg;
   localparam int NUM_CH   = 2;
   localparam int CH_LEFT  = 0;
   localparam int CH_RIGHT = 1;

   typedef enum logic {
      CAUSE_NOT_FULL = 1'b0,
      CAUSE_EMPTY    = 1'b1
   } irq_cause_e;
endpackage

// File: rtl/ssf_pull_timer.sv
`timescale 1ns/1ps
module ssf_pull_timer #(
   parameter int RATIO = 256
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   input  logic tick_i,
   output logic pull_o
);
   localparam int TW = (RATIO > 1) ? $clog2(RATIO) : 1;

   if (RATIO < 2) begin : g_bad_ratio
      $error("ssf_pull_timer: RATIO must be at least 2");
   end

   logic [TW-1:0] cnt_q;

   assign pull_o = en_i && tick_i && (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!en_i) begin
         cnt_q <= '0;
      end else if (tick_i) begin
         cnt_q <= (cnt_q == TW'(RATIO - 1)) ? '0 : cnt_q + 1'b1;
      end
   end

   // R2
   strobe_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pull_o |=> !pull_o);
endmodule

// File: rtl/ssf_chan_buf.sv
`timescale 1ns/1ps
module ssf_chan_buf #(
   parameter int DW    = 16,
   parameter int DEPTH = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en_i,
   input  logic          wr_i,
   input  logic [DW-1:0] wr_data_i,
   input  logic          pop_i,
   input  logic [DW-1:0] dflt_i,
   output logic [DW-1:0] smp_o,
   output logic          full_o,
   output logic          empty_o
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   if (DEPTH < 2) begin : g_bad_depth
      $error("ssf_chan_buf: DEPTH must be at least 2");
   end
   if (DW < 1) begin : g_bad_width
      $error("ssf_chan_buf: DW must be positive");
   end

   logic [DW-1:0] mem_q [DEPTH];
   logic [PW-1:0] rd_q, wr_q, rd_nxt, wr_nxt;
   logic [CW-1:0] cnt_q;
   logic [DW-1:0] smp_q;
   logic          do_pop, do_wr;

   if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
      assign rd_nxt = rd_q + 1'b1;
      assign wr_nxt = wr_q + 1'b1;
   end else begin : g_wrap
      assign rd_nxt = (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      assign wr_nxt = (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
   end

   assign empty_o = (cnt_q == '0);
   assign full_o  = (cnt_q == CW'(DEPTH));
   assign do_pop  = pop_i && !empty_o;
   assign do_wr   = wr_i && en_i && (!full_o || do_pop);
   assign smp_o   = smp_q;

   always_ff @(posedge clk) begin
      if (do_wr) mem_q[wr_q] <= wr_data_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q  <= '0;
         wr_q  <= '0;
         cnt_q <= '0;
         smp_q <= '0;
      end else begin
         if (do_pop) rd_q <= rd_nxt;
         if (do_wr)  wr_q <= wr_nxt;
         case ({do_wr, do_pop})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
         if (pop_i) smp_q <= empty_o ? dflt_i : mem_q[rd_q];
      end
   end

   // R1
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CW'(DEPTH));
   // R4
   dis_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> (cnt_q == $past(cnt_q)));
   // R10
   full_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (full_o && pop_i && wr_i && en_i) |=> full_o);
   // R3
   dflt_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_i && empty_o) |=> (smp_o == $past(dflt_i)));
endmodule

// File: rtl/ssf_irq_gen.sv
`timescale 1ns/1ps
module ssf_irq_gen (
   input  logic clk,
   input  logic rst_n,
   input  logic pull_i,
   input  logic type_i,
   input  logic full_i,
   input  logic empty_i,
   input  logic clr_i,
   output logic pulse_o,
   output logic flag_o
);
   import ssf_pkg::*;

   logic       pull_d_q, flag_q;
   irq_cause_e cause;

   assign cause   = irq_cause_e'(type_i);
   assign pulse_o = pull_d_q && ((cause == CAUSE_EMPTY) ? empty_i : !full_i);
   assign flag_o  = flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pull_d_q <= 1'b0;
         flag_q   <= 1'b0;
      end else begin
         pull_d_q <= pull_i;
         if (pulse_o)     flag_q <= 1'b1;
         else if (clr_i)  flag_q <= 1'b0;
      end
   end

   // R9
   flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_o |=> flag_o);
   // R9
   flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !pulse_o) |=> !flag_o);
endmodule

// File: rtl/stereo_sample_fifo.sv
`timescale 1ns/1ps
module stereo_sample_fifo #(
   parameter int DW    = 16,
   parameter int DEPTH = 4,
   parameter int RATIO = 256
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en_i,
   input  logic          conv_tick_i,
   input  logic [DW-1:0] wr_data_i,
   input  logic          wr_left_i,
   input  logic          wr_right_i,
   input  logic          dflt_we_i,
   input  logic [1:0]    irq_type_i,
   input  logic [1:0]    irq_clr_i,
   output logic [DW-1:0] smp_left_o,
   output logic [DW-1:0] smp_right_o,
   output logic          smp_vld_o,
   output logic [1:0]    full_o,
   output logic [1:0]    empty_o,
   output logic [1:0]    irq_pulse_o,
   output logic [1:0]    irq_flag_o
);
   import ssf_pkg::*;

   logic [DW-1:0] dflt_q;
   logic          pull, vld_q;
   logic [NUM_CH-1:0] wr_vec;
   logic [DW-1:0] smp_arr [NUM_CH];

   assign wr_vec[CH_LEFT]  = wr_left_i;
   assign wr_vec[CH_RIGHT] = wr_right_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dflt_q <= '0;
         vld_q  <= 1'b0;
      end else begin
         if (dflt_we_i) dflt_q <= wr_data_i;
         vld_q <= pull;
      end
   end

   ssf_pull_timer #(.RATIO(RATIO)) timer_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .en_i   (en_i),
      .tick_i (conv_tick_i),
      .pull_o (pull)
   );

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      ssf_chan_buf #(.DW(DW), .DEPTH(DEPTH)) buf_i (
         .clk       (clk),
         .rst_n     (rst_n),
         .en_i      (en_i),
         .wr_i      (wr_vec[ch]),
         .wr_data_i (wr_data_i),
         .pop_i     (pull),
         .dflt_i    (dflt_q),
         .smp_o     (smp_arr[ch]),
         .full_o    (full_o[ch]),
         .empty_o   (empty_o[ch])
      );

      ssf_irq_gen irq_i (
         .clk     (clk),
         .rst_n   (rst_n),
         .pull_i  (pull),
         .type_i  (irq_type_i[ch]),
         .full_i  (full_o[ch]),
         .empty_i (empty_o[ch]),
         .clr_i   (irq_clr_i[ch]),
         .pulse_o (irq_pulse_o[ch]),
         .flag_o  (irq_flag_o[ch])
      );
   end

   assign smp_left_o  = smp_arr[CH_LEFT];
   assign smp_right_o = smp_arr[CH_RIGHT];
   assign smp_vld_o   = vld_q;

   // R2
   vld_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      smp_vld_o |-> $past(pull));
endmodule

// File: tb/stereo_sample_fifo_tb_top.sv
`timescale 1ns/1ps
module stereo_sample_fifo_tb_top;
   localparam int RATIO = 256;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        en_i = 1'b0;
   logic        conv_tick_i = 1'b0;
   logic [15:0] wr_data_i = '0;
   logic        wr_left_i = 1'b0;
   logic        wr_right_i = 1'b0;
   logic        dflt_we_i = 1'b0;
   logic [1:0]  irq_type_i = '0;
   logic [1:0]  irq_clr_i = '0;
   logic [15:0] smp_left_o, smp_right_o;
   logic        smp_vld_o;
   logic [1:0]  full_o, empty_o, irq_pulse_o, irq_flag_o;

   int n_chk = 0;
   int n_bad = 0;
   int phase = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   stereo_sample_fifo dut_i (
      .clk(clk), .rst_n(rst_n), .en_i(en_i), .conv_tick_i(conv_tick_i),
      .wr_data_i(wr_data_i), .wr_left_i(wr_left_i), .wr_right_i(wr_right_i),
      .dflt_we_i(dflt_we_i), .irq_type_i(irq_type_i), .irq_clr_i(irq_clr_i),
      .smp_left_o(smp_left_o), .smp_right_o(smp_right_o), .smp_vld_o(smp_vld_o),
      .full_o(full_o), .empty_o(empty_o), .irq_pulse_o(irq_pulse_o),
      .irq_flag_o(irq_flag_o)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr_word(input bit left, input logic [15:0] d);
      wr_data_i = d; wr_left_i = left; wr_right_i = !left;
      @(negedge clk);
      wr_left_i = 0; wr_right_i = 0;
   endtask

   task automatic set_dflt(input logic [15:0] d);
      wr_data_i = d; dflt_we_i = 1;
      @(negedge clk);
      dflt_we_i = 0;
   endtask

   task automatic clear_flags();
      irq_clr_i = 2'b11;
      @(negedge clk);
      irq_clr_i = 2'b00;
   endtask

   // Ticks up to and including a pull; returns at the negedge after it.
   task automatic do_pull(input bit wl, input logic [15:0] d);
      int pre;
      bit early;
      pre = (RATIO - phase) % RATIO;
      early = 0;
      for (int i = 0; i < pre; i++) begin
         conv_tick_i = 1;
         @(negedge clk);
         if (smp_vld_o) early = 1;
      end
      conv_tick_i = 1; wr_left_i = wl; wr_data_i = d;
      @(negedge clk);
      conv_tick_i = 0; wr_left_i = 0;
      phase = 1;
      check(!early, "R2 no strobe before tick count", 32'(early), 0);
      check(smp_vld_o, "R2 strobe on pull tick", 32'(smp_vld_o), 1);
   endtask

   task automatic t_reset();
      check(empty_o == 2'b11, "R8 reset empty", 32'(empty_o), 3);
      check(full_o == 2'b00, "R8 reset full", 32'(full_o), 0);
      check(irq_flag_o == 2'b00 && smp_vld_o == 0, "R8 reset irq/vld",
            32'({irq_flag_o, smp_vld_o}), 0);
   endtask

   task automatic t_disabled_write();
      wr_word(1, 16'h1111);
      @(negedge clk);
      check(empty_o[0] == 1, "R4 write while disabled dropped", 32'(empty_o), 3);
   endtask

   task automatic t_first_enable();
      set_dflt(16'h8000);
      irq_type_i = 2'b00;
      en_i = 1; phase = 0;
      do_pull(0, '0);
      check(smp_left_o == 16'h8000 && smp_right_o == 16'h8000,
            "R7 first samples are default", 32'({smp_left_o, smp_right_o}), 32'h80008000);
      check(irq_pulse_o == 2'b11, "R7 both irq on first pull", 32'(irq_pulse_o), 3);
      @(negedge clk);
      check(irq_flag_o == 2'b11, "R9 flags set by pulse", 32'(irq_flag_o), 3);
      check(irq_pulse_o == 2'b00, "R9 pulse one cycle", 32'(irq_pulse_o), 0);
      @(negedge clk);
      check(irq_flag_o == 2'b11, "R9 flags stay set", 32'(irq_flag_o), 3);
      irq_clr_i = 2'b01;
      @(negedge clk);
      irq_clr_i = 2'b00;
      check(irq_flag_o == 2'b10, "R9 w1c clears only left", 32'(irq_flag_o), 2);
      clear_flags();
   endtask

   task automatic t_fill_order();
      for (int i = 0; i < 4; i++) wr_word(1, 16'hA000 + 16'(i));
      check(full_o == 2'b01 && empty_o == 2'b10, "R8 left full right empty",
            32'({full_o, empty_o}), 32'h6);
      check(empty_o[1] == 1, "R11 right untouched by left writes", 32'(empty_o[1]), 1);
      wr_word(1, 16'hDEAD);
      check(full_o[0] == 1, "R1 still full after dropped write", 32'(full_o), 1);
      for (int i = 0; i < 4; i++) begin
         do_pull(0, '0);
         check(smp_left_o == 16'hA000 + 16'(i), "R12 order kept",
               32'(smp_left_o), 32'(16'hA000 + 16'(i)));
         check(smp_right_o == 16'h8000, "R11 right gets default",
               32'(smp_right_o), 32'h8000);
         if (i == 0)
            check(irq_pulse_o == 2'b11, "R6 not-full pulse after pull from full",
                  32'(irq_pulse_o), 3);
      end
      do_pull(0, '0);
      check(smp_left_o == 16'h8000, "R1 fifth word was dropped",
            32'(smp_left_o), 32'h8000);
      clear_flags();
   endtask

   task automatic t_irq_empty();
      irq_type_i = 2'b11;
      set_dflt(16'h0000);
      wr_word(1, 16'h1234);
      wr_word(1, 16'h5678);
      do_pull(0, '0);
      check(smp_left_o == 16'h1234 && smp_right_o == 16'h0000, "R3 new default used",
            32'({smp_left_o, smp_right_o}), 32'h12340000);
      check(irq_pulse_o == 2'b10, "R5 only empty channel pulses",
            32'(irq_pulse_o), 2);
      do_pull(0, '0);
      check(irq_pulse_o == 2'b11, "R5 both empty after drain", 32'(irq_pulse_o), 3);
      clear_flags();
   endtask

   task automatic t_concurrent();
      irq_type_i = 2'b00;
      for (int i = 0; i < 4; i++) wr_word(1, 16'hB000 + 16'(i));
      do_pull(1, 16'hB004);
      check(full_o[0] == 1 && smp_left_o == 16'hB000, "R10 write and pull on full",
            32'({full_o[0], smp_left_o}), 32'h1B000);
      check(irq_pulse_o[0] == 0, "R6 no pulse when still full", 32'(irq_pulse_o), 2);
      for (int i = 1; i < 5; i++) begin
         do_pull(0, '0);
         check(smp_left_o == 16'hB000 + 16'(i), "R10 swapped word in order",
               32'(smp_left_o), 32'(16'hB000 + 16'(i)));
      end
      do_pull(1, 16'hC001);
      check(smp_left_o == 16'h0000 && empty_o[0] == 0,
            "R3 empty pull gives default while write lands",
            32'({empty_o[0], smp_left_o}), 0);
      do_pull(0, '0);
      check(smp_left_o == 16'hC001, "R12 late write read next", 32'(smp_left_o), 32'hC001);
      clear_flags();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_disabled_write();
      t_first_enable();
      t_fill_order();
      t_irq_empty();
      t_concurrent();
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
         $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
         $finish;
      end
   end
endmodule